// File: doc/BRIEF.md
# Power Management Event Interrupt Unit

This unit raises the system control interrupt for a power-management event block. It keeps a 16-bit event status register and a 16-bit event enable register. Single-cycle pulses on the event inputs set status bits. Software clears a status bit by writing a one to it. The interrupt line is a registered level. It is high while any of four watched sources has both its status bit and its enable bit set. The unit also drives a registered arm signal for an external periodic timer. The signal is high only while the timer event is enabled and its status bit is clear, so the timer runs only until its overflow has been recorded.

The unit also places a 64-byte I/O window in a 16-bit address space. The window base comes from a 32-bit configuration register, with the low six bits forced to zero. The window is switched on by bit 0 of a configuration control register. Each access presented to the unit gets a registered hit flag and the byte offset inside the window.

Top module: `pmei_top`

## Requirements
- R1: After synchronous reset, status, enable, `irq`, `tmr_arm`, `win_en`, `win_base`, `win_hit` and `win_off` are all zero.
- R2: A one on bit i of `evt_set` sets status bit i at the next clock edge, and the bit stays set until it is cleared by software.
- R3: A status write (`reg_wr`=1, `reg_sel`=0) clears each status bit whose data bit is 1 and leaves the bits with data 0 unchanged. If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: An enable write (`reg_wr`=1, `reg_sel`=1) loads the enable register with the data, which then reads back unchanged on `en_q`.
- R5: `irq` is high one cycle after status AND enable has a one in any of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock). Matching bits elsewhere, such as bit 1, never raise it.
- R6: `irq` falls in the cycle after the last matching status bit or enable bit is cleared. It is a level, not a pulse.
- R7: `tmr_arm` is high one cycle after enable bit 0 is 1 while status bit 0 is 0, and low otherwise.
- R8: A configuration write to offset 0x40 sets `win_base` to bits [15:0] of the data ANDed with 0xFFC0. Writes to any other offset except 0x80 change nothing.
- R9: A configuration write to offset 0x80 sets `win_en` to data bit 0. While `win_en` is 0, no access hits.
- R10: One cycle after an access A with `acc_valid`=1, `win_hit` is 1 exactly when the window is enabled and base <= A < base + 64, with `win_off` = A - base. This includes a window at 0xFFC0, which reaches the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 16 | Event pulses, one per status bit |
| reg_wr | input | 1 | Event register write strobe |
| reg_sel | input | 1 | 0 = status (write-one-to-clear), 1 = enable |
| reg_wdata | input | 16 | Event register write data |
| sts_q | output | 16 | Status register |
| en_q | output | 16 | Enable register |
| irq | output | 1 | Interrupt level |
| tmr_arm | output | 1 | Periodic timer arm |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 16 | Access address |
| win_base | output | 16 | Window base address |
| win_en | output | 1 | Window enable |
| win_hit | output | 1 | Registered window hit |
| win_off | output | 6 | Registered offset inside window |

## Verification
The assertions assume that event pulses, register writes and accesses are sampled only on clock edges, and that any input may change in any cycle. They also assume no particular order between a clearing write and an event pulse, because set-over-clear is itself checked. The bench changes inputs only on the falling edge. It holds each strobe for exactly one cycle and keeps access addresses within 16 bits. That keeps it inside those assumptions, and it still exercises the same-cycle set/clear collision and the window at the top of the address space.

// File: rtl/pmei_pkg.sv
package pmei_pkg;
  localparam int EVT_W   = 16;
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [EVT_W-1:0] IRQ_SRC_MASK =
    EVT_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));
  typedef enum logic {SEL_STS = 1'b0, SEL_EN = 1'b1} evt_sel_e;
endpackage

// File: rtl/pmei_evt_regs.sv
module pmei_evt_regs
  import pmei_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] en_q
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] sts_nxt;

  always_comb begin
    clr_mask = (reg_wr && reg_sel == SEL_STS) ? reg_wdata : '0;
    sts_nxt  = (sts_q & ~clr_mask) | evt_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_nxt;
      if (reg_wr && reg_sel == SEL_EN) en_q <= reg_wdata;
    end
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_STS) |=>
      ((sts_q & $past(reg_wdata) & ~$past(evt_set)) == '0));

  assert_en_load_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == SEL_EN) |=> (en_q == $past(reg_wdata)));
endmodule

// File: rtl/pmei_irq_gen.sv
module pmei_irq_gen
  import pmei_pkg::*;
#(
  parameter int           W        = EVT_W,
  parameter logic [W-1:0] SRC_MASK = IRQ_SRC_MASK,
  parameter int           TMR_BIT  = BIT_TMR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sts_q,
  input  logic [W-1:0] en_q,
  output logic         irq,
  output logic         tmr_arm
);
  logic pend;
  logic arm_nxt;

  always_comb begin
    pend    = |(sts_q & en_q & SRC_MASK);
    arm_nxt = en_q[TMR_BIT] & ~sts_q[TMR_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      tmr_arm <= 1'b0;
    end else begin
      irq     <= pend;
      tmr_arm <= arm_nxt;
    end
  end

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (|(sts_q & en_q & SRC_MASK)) |=> irq);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
    !(|(sts_q & en_q & SRC_MASK)) |=> !irq);

  assert_arm_cond_R7: assert property (@(posedge clk) disable iff (rst)
    (en_q[TMR_BIT] && !sts_q[TMR_BIT]) |=> tmr_arm);

  assert_arm_drop_R7: assert property (@(posedge clk) disable iff (rst)
    sts_q[TMR_BIT] |=> !tmr_arm);
endmodule

// File: rtl/pmei_io_window.sv
module pmei_io_window #(
  parameter int             ADDR_W    = 16,
  parameter int             CFG_W     = 32,
  parameter int             CFG_AW    = 8,
  parameter logic [CFG_AW-1:0] BASE_OFF = 8'h40,
  parameter logic [CFG_AW-1:0] CTRL_OFF = 8'h80,
  parameter int             WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] win_base,
  output logic              win_en,
  output logic              win_hit,
  output logic [$clog2(WIN_BYTES)-1:0] win_off
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WIN_BYTES - 1);

  logic              unused_cfg_bits;
  logic [ADDR_W:0]   win_end;
  logic [ADDR_W-1:0] rel;
  logic              in_win;

  assign unused_cfg_bits = ^cfg_wdata[CFG_W-1:ADDR_W];

  always_comb begin
    win_end = {1'b0, win_base} + (ADDR_W+1)'(WIN_BYTES);
    rel     = acc_addr - win_base;
    in_win  = acc_valid && win_en && (acc_addr >= win_base) &&
              ({1'b0, acc_addr} < win_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_base <= '0;
      win_en   <= 1'b0;
      win_hit  <= 1'b0;
      win_off  <= '0;
    end else begin
      if (cfg_wr && cfg_addr == BASE_OFF) win_base <= cfg_wdata[ADDR_W-1:0] & ALIGN_MASK;
      if (cfg_wr && cfg_addr == CTRL_OFF) win_en   <= cfg_wdata[0];
      win_hit <= in_win;
      win_off <= in_win ? rel[OFF_W-1:0] : '0;
    end
  end

  assert_base_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && cfg_addr == BASE_OFF) |=> $stable(win_base));

  assert_en_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !win_en |=> !win_hit);

  assert_hit_valid_R10: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> $past(acc_valid));
endmodule

// File: rtl/pmei_top.sv
module pmei_top
  import pmei_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CFG_W     = 32,
  parameter int CFG_AW    = 8,
  parameter int WIN_BYTES = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [EVT_W-1:0]             evt_set,
  input  logic                         reg_wr,
  input  logic                         reg_sel,
  input  logic [EVT_W-1:0]             reg_wdata,
  output logic [EVT_W-1:0]             sts_q,
  output logic [EVT_W-1:0]             en_q,
  output logic                         irq,
  output logic                         tmr_arm,
  input  logic                         cfg_wr,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [CFG_W-1:0]             cfg_wdata,
  input  logic                         acc_valid,
  input  logic [ADDR_W-1:0]            acc_addr,
  output logic [ADDR_W-1:0]            win_base,
  output logic                         win_en,
  output logic                         win_hit,
  output logic [$clog2(WIN_BYTES)-1:0] win_off
);
  pmei_evt_regs #(.W(EVT_W)) u_regs (
    .clk(clk), .rst(rst), .evt_set(evt_set), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .sts_q(sts_q), .en_q(en_q)
  );

  pmei_irq_gen #(.W(EVT_W), .SRC_MASK(IRQ_SRC_MASK), .TMR_BIT(BIT_TMR)) u_irq (
    .clk(clk), .rst(rst), .sts_q(sts_q), .en_q(en_q),
    .irq(irq), .tmr_arm(tmr_arm)
  );

  pmei_io_window #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CFG_AW(CFG_AW),
    .BASE_OFF(CFG_AW'(8'h40)), .CTRL_OFF(CFG_AW'(8'h80)), .WIN_BYTES(WIN_BYTES)
  ) u_win (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .win_base(win_base), .win_en(win_en), .win_hit(win_hit), .win_off(win_off)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && !tmr_arm && !win_hit && sts_q == '0 && en_q == '0));
endmodule

// File: tb/tb_pmei_top.sv
module tb_pmei_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_set = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] sts_q, en_q;
  logic        irq, tmr_arm;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [15:0] win_base;
  logic        win_en, win_hit;
  logic [5:0]  win_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pmei_top dut (
    .clk(clk), .rst(rst), .evt_set(evt_set), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sts_q(sts_q), .en_q(en_q), .irq(irq), .tmr_arm(tmr_arm),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .win_base(win_base),
    .win_en(win_en), .win_hit(win_hit), .win_off(win_off)
  );

  function automatic logic [31:0] observe(int k);
    case (k)
      0: return {16'h0, sts_q};
      1: return {16'h0, en_q};
      2: return {31'h0, irq};
      3: return {31'h0, tmr_arm};
      4: return {16'h0, win_base};
      5: return {31'h0, win_en};
      6: return {31'h0, win_hit};
      default: return {26'h0, win_off};
    endcase
  endfunction

  // monitor: pops expected items shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it  = sb.pop_front();
      got = observe(it.kind);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(int k, logic [31:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  task automatic pulse(logic [15:0] v);
    evt_set = v; tick(); evt_set = '0;
  endtask

  task automatic wr_reg(logic sel, logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  task automatic wr_cfg(logic [7:0] a, logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; tick(); cfg_wr = 1'b0;
  endtask

  task automatic access(logic [15:0] a, logic h, logic [5:0] o, string r);
    acc_valid = 1'b1; acc_addr = a; tick(); acc_valid = 1'b0;
    chk(6, {31'h0, h}, r); chk(7, {26'h0, o}, r);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    // R1 reset state
    chk(0, 0, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, 0, "R1");
    chk(4, 0, "R1"); chk(5, 0, "R1"); chk(6, 0, "R1"); chk(7, 0, "R1");

    // R2 power-button event with enable clear: status sets, no irq
    pulse(16'h0100); chk(0, 32'h0100, "R2"); tick(); chk(2, 0, "R5");
    // R4 enable write, R5 irq rises
    wr_reg(1'b1, 16'h0100); chk(1, 32'h0100, "R4"); tick(); chk(2, 1, "R5");
    // R3 writing zero keeps status
    wr_reg(1'b0, 16'h0000); chk(0, 32'h0100, "R3"); tick(); chk(2, 1, "R6");
    // R3 W1C clears, R6 irq drops
    wr_reg(1'b0, 16'h0100); chk(0, 0, "R3"); tick(); chk(2, 0, "R6");

    // R5 non-source bit 1 never raises irq
    wr_reg(1'b1, 16'hFFFE); pulse(16'h0002); chk(0, 32'h0002, "R2");
    tick(); chk(2, 0, "R5");
    wr_reg(1'b0, 16'hFFFF);
    // R5 real-time clock source, R6 drop on enable clear
    pulse(16'h0400); tick(); chk(2, 1, "R5");
    wr_reg(1'b1, 16'h0000); tick(); chk(2, 0, "R6");
    wr_reg(1'b0, 16'hFFFF);
    // R5 global lock source
    wr_reg(1'b1, 16'h0020); pulse(16'h0020); tick(); chk(2, 1, "R5");
    wr_reg(1'b0, 16'h0020); tick(); chk(2, 0, "R6");

    // R7 timer arm
    wr_reg(1'b1, 16'h0001); tick(); chk(3, 1, "R7"); chk(2, 0, "R7");
    pulse(16'h0001); tick(); chk(3, 0, "R7"); chk(2, 1, "R5");
    wr_reg(1'b0, 16'h0001); tick(); chk(3, 1, "R7"); chk(2, 0, "R6");

    // R3 set wins over same-cycle clear
    evt_set = 16'h0100; wr_reg(1'b0, 16'h0100); evt_set = '0;
    chk(0, 32'h0100, "R3");
    wr_reg(1'b0, 16'hFFFF); chk(0, 0, "R3");

    // R8 base masking and ignored offsets
    wr_cfg(8'h40, 32'h1234_ABCD); chk(4, 32'hABC0, "R8");
    wr_cfg(8'h44, 32'h0000_5555); chk(4, 32'hABC0, "R8");
    // R9 disabled window never hits
    access(16'hABC5, 1'b0, 6'd0, "R9");
    wr_cfg(8'h80, 32'h0000_0001); chk(5, 1, "R9");
    // R10 boundaries
    access(16'hABC0, 1'b1, 6'd0,  "R10");
    access(16'hABFF, 1'b1, 6'd63, "R10");
    access(16'hAC00, 1'b0, 6'd0,  "R10");
    access(16'hABBF, 1'b0, 6'd0,  "R10");
    wr_cfg(8'h40, 32'h0000_FFFF); chk(4, 32'hFFC0, "R8");
    access(16'hFFFF, 1'b1, 6'd63, "R10");
    access(16'hFFC1, 1'b1, 6'd1,  "R10");
    wr_cfg(8'h80, 32'h0000_0002); chk(5, 0, "R9");
    access(16'hFFC1, 1'b0, 6'd0,  "R9");

    tick(); tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule